// File: doc/BRIEF.md
# Read Data Window Margin Scanner

This block measures how much timing margin each byte group of a multi-byte read data path has. For one byte group at a time, it moves that group's fine phase-delay tap away from its present position, one tap per step, and watches the sticky pass/fail flag of an external traffic checker. It first walks toward tap 0 to find the left edge of the valid window. It then returns to the starting tap and walks toward the top tap to find the right edge. Finally it puts the tap back where it started. The two margins are stored per byte and any byte's pair can be read out on the result ports.

The delay line is outside the block. The block drives it with one-cycle increment and decrement strobes plus a byte index, and it keeps its own record of each byte's present tap. It computes that record from the calibrated taps it is given, adjusted by every strobe it has issued. After every strobe it pulses a clear to the traffic checker, so that the next sample reflects only the new tap. Outside a scan, single taps of a chosen byte can be stepped by hand, and the chosen byte can be moved up or down.

Top module: `rd_eye_scanner`

## Requirements
- R1: A one-cycle `scan_go` while idle and `path_sel` equal to 1 raises `scan_active` in the next cycle, with `cur_byte` at 0.
- R2: `scan_active` stays high until the right edge of the last byte group (index NUM_BYTES-1) has been stored and its tap restored. It then falls, leaving `cur_byte` at NUM_BYTES-1.
- R3: `path_sel` is a 2-bit selector in which only the value 1 (read path) enables the block. With any other value, `scan_go` and the manual tap pulses are ignored: no strobe is issued and `cur_tap` does not change.
- R4: The left result of a byte is the number of consecutive decrement steps from its starting tap after which `chk_err` was still low. Each step's flag is sampled SETTLE_CYC cycles after the strobe, and the walk stops at tap 0 without error.
- R5: The right result of a byte is the number of consecutive increment steps from its starting tap after which `chk_err` was still low. It is sampled the same way, and the walk stops at tap TAP_COUNT-1 without error.
- R6: After a byte is measured, its tap is stepped back to the tap it had when its measurement began, before the next byte starts.
- R7: `err_clr` is high for exactly the cycle that follows each cycle in which `tap_inc` or `tap_dec` is high, and at no other time.
- R8: `tap_inc` and `tap_dec` are never high together, and a strobe is never high in two consecutive cycles.
- R9: Outside a scan, with `path_sel` equal to 1, `man_tap_up` or `man_tap_dn` moves the tap of byte `cur_byte` by one. A step that would go below 0 or above TAP_COUNT-1 is dropped.
- R10: Outside a scan, `man_byte_up` and `man_byte_dn` move `cur_byte` by one, wrapping between NUM_BYTES-1 and 0.
- R11: While `scan_active` is high, the four manual inputs have no effect on taps, results or `cur_byte`.
- R12: `res_left` and `res_right` show the stored results of byte `rd_sel`, and all results are 0 after reset.
- R13: `cur_tap` shows the present tap of byte `cur_byte`, which is its calibrated tap plus all net strobes applied to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| path_sel | input | 2 | Path selector; 1 enables read-window work |
| scan_go | input | 1 | One-cycle pulse that starts a full sweep |
| chk_err | input | 1 | Sticky error flag from the traffic checker |
| cal_taps | input | NUM_BYTES*TAP_W | Calibrated tap of each byte, byte 0 in the low bits |
| man_tap_up | input | 1 | Manual one-tap increment pulse |
| man_tap_dn | input | 1 | Manual one-tap decrement pulse |
| man_byte_up | input | 1 | Move selected byte up by one |
| man_byte_dn | input | 1 | Move selected byte down by one |
| rd_sel | input | BYTE_W | Byte whose results are shown |
| scan_active | output | 1 | High while a sweep is running |
| cur_byte | output | BYTE_W | Byte under test or selected for manual steps |
| cur_tap | output | TAP_W | Present tap of `cur_byte` |
| tap_inc | output | 1 | One-cycle tap increment strobe |
| tap_dec | output | 1 | One-cycle tap decrement strobe |
| tap_byte | output | BYTE_W | Byte the strobe applies to |
| err_clr | output | 1 | One-cycle clear for the checker's sticky error |
| res_left | output | TAP_W | Stored left margin of byte `rd_sel` |
| res_right | output | TAP_W | Stored right margin of byte `rd_sel` |

## Verification
A corrupted tap record shows up at once on `cur_tap`. It also makes a sweep stop at the wrong place, so the stored margins read back one or more taps off, and a byte fails to return to its calibrated tap when the bytes are walked afterwards. A wrong sweep state or settle count shows up as margins that disagree with the eye model in the bench, usually by one tap. Such faults also show as an `err_clr` that does not trail its strobe by exactly one cycle, which the bench sees within a cycle of the fault. A byte counter that moves during a sweep shows up as `cur_byte` other than the last byte when `scan_active` falls.

// File: rtl/eye_scan_pkg.sv
package eye_scan_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BEGIN,
    ST_LSTEP,
    ST_LWAIT,
    ST_LRET,
    ST_LGAP,
    ST_RSTEP,
    ST_RWAIT,
    ST_RRET,
    ST_RGAP,
    ST_NEXT
  } scan_state_e;

  localparam logic [1:0] PATH_READ = 2'd1;

endpackage

// File: rtl/eye_tap_track.sv
module eye_tap_track #(
  parameter int NUM_BYTES = 8,
  parameter int TAP_COUNT = 64,
  localparam int BYTE_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int TAP_W  = $clog2(TAP_COUNT)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        step_inc,
  input  logic                        step_dec,
  input  logic [BYTE_W-1:0]           step_byte,
  input  logic [NUM_BYTES*TAP_W-1:0]  cal_taps,
  input  logic [BYTE_W-1:0]           view_byte,
  output logic [TAP_W-1:0]            view_tap
);

  localparam logic [TAP_W-1:0] TAP_MAX = TAP_W'(TAP_COUNT - 1);
  localparam logic [TAP_W:0]   ONE     = (TAP_W+1)'(1);

  logic [TAP_W-1:0] tap_all [NUM_BYTES];

  // Each byte keeps a two's complement offset from its calibrated tap.
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic [TAP_W:0] off_q;
    logic [TAP_W:0] off_d;
    logic [TAP_W:0] sum;
    logic           hit;

    assign hit = (step_byte == BYTE_W'(g));
    assign sum = {1'b0, cal_taps[g*TAP_W +: TAP_W]} + off_q;
    assign tap_all[g] = sum[TAP_W-1:0];

    always_comb begin
      off_d = off_q;
      if (hit && step_inc)      off_d = off_q + ONE;
      else if (hit && step_dec) off_d = off_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) off_q <= '0;
      else        off_q <= off_d;
    end

    assert_tap_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (step_dec && hit) |-> (tap_all[g] != '0));
    assert_tap_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (step_inc && hit) |-> (tap_all[g] != TAP_MAX));
  end

  assign view_tap = tap_all[view_byte];

endmodule

// File: rtl/eye_result_store.sv
module eye_result_store #(
  parameter int NUM_BYTES = 8,
  parameter int TAP_COUNT = 64,
  localparam int BYTE_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int TAP_W  = $clog2(TAP_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_left,
  input  logic              wr_right,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [TAP_W-1:0]  wr_val,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [TAP_W-1:0]  rd_left,
  output logic [TAP_W-1:0]  rd_right
);

  logic [TAP_W-1:0] left_q  [NUM_BYTES];
  logic [TAP_W-1:0] right_q [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_slot
    logic sel;
    logic [TAP_W-1:0] left_d;
    logic [TAP_W-1:0] right_d;

    assign sel = (wr_byte == BYTE_W'(g));

    always_comb begin
      left_d  = left_q[g];
      right_d = right_q[g];
      if (sel && wr_left)  left_d  = wr_val;
      if (sel && wr_right) right_d = wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        left_q[g]  <= '0;
        right_q[g] <= '0;
      end else begin
        left_q[g]  <= left_d;
        right_q[g] <= right_d;
      end
    end
  end

  assign rd_left  = left_q[rd_byte];
  assign rd_right = right_q[rd_byte];

  assert_one_side_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_left && wr_right));

endmodule

// File: rtl/eye_scan_ctrl.sv
module eye_scan_ctrl
  import eye_scan_pkg::*;
#(
  parameter int NUM_BYTES  = 8,
  parameter int TAP_COUNT  = 64,
  parameter int SETTLE_CYC = 4,
  localparam int BYTE_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int TAP_W  = $clog2(TAP_COUNT),
  localparam int SET_W  = $clog2(SETTLE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        path_sel,
  input  logic              scan_go,
  input  logic              chk_err,
  input  logic              man_tap_up,
  input  logic              man_tap_dn,
  input  logic              man_byte_up,
  input  logic              man_byte_dn,
  input  logic [TAP_W-1:0]  cur_tap,
  output logic              scan_active,
  output logic [BYTE_W-1:0] cur_byte,
  output logic              tap_inc,
  output logic              tap_dec,
  output logic [BYTE_W-1:0] tap_byte,
  output logic              err_clr,
  output logic              wr_left,
  output logic              wr_right,
  output logic [TAP_W-1:0]  wr_val
);

  localparam logic [TAP_W-1:0]  TAP_MAX   = TAP_W'(TAP_COUNT - 1);
  localparam logic [BYTE_W-1:0] BYTE_LAST = BYTE_W'(NUM_BYTES - 1);
  localparam logic [SET_W-1:0]  SET_LOAD  = SET_W'(SETTLE_CYC - 1);

  scan_state_e       state_q, state_d;
  logic [BYTE_W-1:0] byte_q,  byte_d;
  logic [TAP_W-1:0]  home_q,  home_d;
  logic [TAP_W-1:0]  cnt_q,   cnt_d;
  logic [SET_W-1:0]  settle_q, settle_d;
  logic              inc_q, inc_d;
  logic              dec_q, dec_d;
  logic [BYTE_W-1:0] sbyte_q, sbyte_d;
  logic              clr_q, clr_d;
  logic              path_ok;
  logic              pend;

  assign path_ok = (path_sel == PATH_READ);
  assign pend    = inc_q | dec_q;

  always_comb begin
    state_d  = state_q;
    byte_d   = byte_q;
    home_d   = home_q;
    cnt_d    = cnt_q;
    settle_d = settle_q;
    inc_d    = 1'b0;
    dec_d    = 1'b0;
    sbyte_d  = sbyte_q;
    clr_d    = pend;
    wr_left  = 1'b0;
    wr_right = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (scan_go && path_ok) begin
          state_d = ST_BEGIN;
          byte_d  = '0;
        end else begin
          if (path_ok && !pend) begin
            if (man_tap_up && !man_tap_dn && cur_tap != TAP_MAX) begin
              inc_d   = 1'b1;
              sbyte_d = byte_q;
            end else if (man_tap_dn && !man_tap_up && cur_tap != '0) begin
              dec_d   = 1'b1;
              sbyte_d = byte_q;
            end
          end
          if (man_byte_up && !man_byte_dn)
            byte_d = (byte_q == BYTE_LAST) ? '0 : byte_q + 1'b1;
          else if (man_byte_dn && !man_byte_up)
            byte_d = (byte_q == '0) ? BYTE_LAST : byte_q - 1'b1;
        end
      end

      ST_BEGIN: begin
        if (!pend) begin
          home_d  = cur_tap;
          cnt_d   = '0;
          state_d = ST_LSTEP;
        end
      end

      ST_LSTEP: begin
        if (cur_tap == '0) begin
          wr_left = 1'b1;
          state_d = ST_LRET;
        end else begin
          dec_d    = 1'b1;
          sbyte_d  = byte_q;
          settle_d = SET_LOAD;
          state_d  = ST_LWAIT;
        end
      end

      ST_LWAIT: begin
        if (settle_q != '0) begin
          settle_d = settle_q - 1'b1;
        end else if (chk_err) begin
          wr_left = 1'b1;
          state_d = ST_LRET;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          state_d = ST_LSTEP;
        end
      end

      ST_LRET: begin
        if (cur_tap == home_q) begin
          cnt_d   = '0;
          state_d = ST_RSTEP;
        end else begin
          inc_d   = (cur_tap < home_q);
          dec_d   = (cur_tap > home_q);
          sbyte_d = byte_q;
          state_d = ST_LGAP;
        end
      end

      ST_LGAP: state_d = ST_LRET;

      ST_RSTEP: begin
        if (cur_tap == TAP_MAX) begin
          wr_right = 1'b1;
          state_d  = ST_RRET;
        end else begin
          inc_d    = 1'b1;
          sbyte_d  = byte_q;
          settle_d = SET_LOAD;
          state_d  = ST_RWAIT;
        end
      end

      ST_RWAIT: begin
        if (settle_q != '0) begin
          settle_d = settle_q - 1'b1;
        end else if (chk_err) begin
          wr_right = 1'b1;
          state_d  = ST_RRET;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          state_d = ST_RSTEP;
        end
      end

      ST_RRET: begin
        if (cur_tap == home_q) begin
          state_d = ST_NEXT;
        end else begin
          inc_d   = (cur_tap < home_q);
          dec_d   = (cur_tap > home_q);
          sbyte_d = byte_q;
          state_d = ST_RGAP;
        end
      end

      ST_RGAP: state_d = ST_RRET;

      ST_NEXT: begin
        if (byte_q == BYTE_LAST) begin
          state_d = ST_IDLE;
        end else begin
          byte_d  = byte_q + 1'b1;
          state_d = ST_BEGIN;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      byte_q   <= '0;
      home_q   <= '0;
      cnt_q    <= '0;
      settle_q <= '0;
      inc_q    <= 1'b0;
      dec_q    <= 1'b0;
      sbyte_q  <= '0;
      clr_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      byte_q   <= byte_d;
      home_q   <= home_d;
      cnt_q    <= cnt_d;
      settle_q <= settle_d;
      inc_q    <= inc_d;
      dec_q    <= dec_d;
      sbyte_q  <= sbyte_d;
      clr_q    <= clr_d;
    end
  end

  assign scan_active = (state_q != ST_IDLE);
  assign cur_byte    = byte_q;
  assign tap_inc     = inc_q;
  assign tap_dec     = dec_q;
  assign tap_byte    = sbyte_q;
  assign err_clr     = clr_q;
  assign wr_val      = cnt_q;

  assert_start_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_active) |-> $past(scan_go && path_sel == PATH_READ));
  assert_byte_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cur_byte <= BYTE_LAST);
  assert_manual_path_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_active && (tap_inc || tap_dec)) |-> $past(path_sel == PATH_READ));
  assert_clr_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_inc || tap_dec) |=> err_clr);
  assert_clr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |-> $past(tap_inc || tap_dec));
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(tap_inc && tap_dec));
  assert_strobe_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tap_inc || tap_dec) |=> !(tap_inc || tap_dec));
  assert_byte_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_active && $past(scan_active) && $past(state_q) != ST_NEXT) |-> $stable(cur_byte));

endmodule

// File: rtl/rd_eye_scanner.sv
module rd_eye_scanner #(
  parameter int NUM_BYTES  = 8,
  parameter int TAP_COUNT  = 64,
  parameter int SETTLE_CYC = 4,
  localparam int BYTE_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1,
  localparam int TAP_W  = $clog2(TAP_COUNT)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 path_sel,
  input  logic                       scan_go,
  input  logic                       chk_err,
  input  logic [NUM_BYTES*TAP_W-1:0] cal_taps,
  input  logic                       man_tap_up,
  input  logic                       man_tap_dn,
  input  logic                       man_byte_up,
  input  logic                       man_byte_dn,
  input  logic [BYTE_W-1:0]          rd_sel,
  output logic                       scan_active,
  output logic [BYTE_W-1:0]          cur_byte,
  output logic [TAP_W-1:0]           cur_tap,
  output logic                       tap_inc,
  output logic                       tap_dec,
  output logic [BYTE_W-1:0]          tap_byte,
  output logic                       err_clr,
  output logic [TAP_W-1:0]           res_left,
  output logic [TAP_W-1:0]           res_right
);

  logic             wr_left;
  logic             wr_right;
  logic [TAP_W-1:0] wr_val;

  eye_scan_ctrl #(
    .NUM_BYTES (NUM_BYTES),
    .TAP_COUNT (TAP_COUNT),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .path_sel   (path_sel),
    .scan_go    (scan_go),
    .chk_err    (chk_err),
    .man_tap_up (man_tap_up),
    .man_tap_dn (man_tap_dn),
    .man_byte_up(man_byte_up),
    .man_byte_dn(man_byte_dn),
    .cur_tap    (cur_tap),
    .scan_active(scan_active),
    .cur_byte   (cur_byte),
    .tap_inc    (tap_inc),
    .tap_dec    (tap_dec),
    .tap_byte   (tap_byte),
    .err_clr    (err_clr),
    .wr_left    (wr_left),
    .wr_right   (wr_right),
    .wr_val     (wr_val)
  );

  eye_tap_track #(
    .NUM_BYTES(NUM_BYTES),
    .TAP_COUNT(TAP_COUNT)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_inc (tap_inc),
    .step_dec (tap_dec),
    .step_byte(tap_byte),
    .cal_taps (cal_taps),
    .view_byte(cur_byte),
    .view_tap (cur_tap)
  );

  eye_result_store #(
    .NUM_BYTES(NUM_BYTES),
    .TAP_COUNT(TAP_COUNT)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_left (wr_left),
    .wr_right(wr_right),
    .wr_byte (cur_byte),
    .wr_val  (wr_val),
    .rd_byte (rd_sel),
    .rd_left (res_left),
    .rd_right(res_right)
  );

endmodule

// File: tb/test_rd_eye_scanner.sv
module test_rd_eye_scanner;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int TW = 6;
  localparam int BW = 3;
  localparam int TMAX = 63;

  logic          clk;
  logic          rst_n;
  logic [1:0]    path_sel;
  logic          scan_go;
  logic          chk_err;
  logic [NB*TW-1:0] cal_taps;
  logic          man_tap_up, man_tap_dn, man_byte_up, man_byte_dn;
  logic [BW-1:0] rd_sel;
  logic          scan_active;
  logic [BW-1:0] cur_byte;
  logic [TW-1:0] cur_tap;
  logic          tap_inc, tap_dec;
  logic [BW-1:0] tap_byte;
  logic          err_clr;
  logic [TW-1:0] res_left, res_right;

  int cal [NB] = '{30, 5, 60, 0, 63, 32, 10, 40};
  int lo  [NB] = '{20, 0, 50, 0, 55, 32,  3,  0};
  int hi  [NB] = '{40, 12, 63, 10, 63, 32, 50, 63};
  int tm  [NB];

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct { int b; int l; int r; } exp_t;
  exp_t sb_q[$];

  rd_eye_scanner #(.NUM_BYTES(NB), .TAP_COUNT(64), .SETTLE_CYC(4)) i_rd_eye_scanner (
    .clk(clk), .rst_n(rst_n), .path_sel(path_sel), .scan_go(scan_go),
    .chk_err(chk_err), .cal_taps(cal_taps), .man_tap_up(man_tap_up),
    .man_tap_dn(man_tap_dn), .man_byte_up(man_byte_up), .man_byte_dn(man_byte_dn),
    .rd_sel(rd_sel), .scan_active(scan_active), .cur_byte(cur_byte),
    .cur_tap(cur_tap), .tap_inc(tap_inc), .tap_dec(tap_dec), .tap_byte(tap_byte),
    .err_clr(err_clr), .res_left(res_left), .res_right(res_right)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Delay line and traffic checker model: any byte outside its window sets a sticky error.
  logic out_any;
  always_comb begin
    out_any = 1'b0;
    for (int b = 0; b < NB; b++)
      if (tm[b] < lo[b] || tm[b] > hi[b]) out_any = 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) tm[b] <= cal[b];
      chk_err <= 1'b0;
    end else begin
      if (tap_inc) tm[tap_byte] <= tm[tap_byte] + 1;
      if (tap_dec) tm[tap_byte] <= tm[tap_byte] - 1;
      chk_err <= (chk_err & ~err_clr) | out_any;
    end
  end

  // Strobe and clear protocol monitor (R7, R8).
  logic prev_strobe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_strobe || err_clr) check("R7 err_clr trails strobe", int'(err_clr), int'(prev_strobe));
      if (tap_inc && tap_dec) check("R8 both strobes", 1, 0);
      if (prev_strobe && (tap_inc || tap_dec)) check("R8 back-to-back strobes", 1, 0);
      prev_strobe = tap_inc | tap_dec;
    end else begin
      prev_strobe = 1'b0;
    end
  end

  // Scoreboard monitor: after each sweep, pop expectations and read each byte back (R4, R5, R12).
  initial begin
    rd_sel = '0;
    forever begin
      @(negedge scan_active);
      while (sb_q.size() > 0) begin
        exp_t it;
        it = sb_q.pop_front();
        @(negedge clk) rd_sel = BW'(it.b);
        @(negedge clk);
        check($sformatf("R4 left byte %0d", it.b),  int'(res_left),  it.l);
        check($sformatf("R5 right byte %0d", it.b), int'(res_right), it.r);
      end
    end
  end

  task automatic push_expect(input int b, input int home);
    exp_t it;
    it.b = b;
    it.l = home - lo[b];
    it.r = hi[b] - home;
    sb_q.push_back(it);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: man_tap_up  = 1'b1;
      1: man_tap_dn  = 1'b1;
      2: man_byte_up = 1'b1;
      default: man_byte_dn = 1'b1;
    endcase
    @(negedge clk);
    man_tap_up = 1'b0; man_tap_dn = 1'b0; man_byte_up = 1'b0; man_byte_dn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_scan();
    @(negedge clk) scan_go = 1'b1;
    @(negedge clk) scan_go = 1'b0;
    check("R1 active after start", int'(scan_active), 1);
    check("R1 first byte", int'(cur_byte), 0);
  endtask

  task automatic finish_scan();
    while (scan_active) @(negedge clk);
    check("R2 last byte at end", int'(cur_byte), NB-1);
    wait (sb_q.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int home [NB];
    rst_n = 1'b0; path_sel = 2'd1; scan_go = 1'b0;
    man_tap_up = 1'b0; man_tap_dn = 1'b0; man_byte_up = 1'b0; man_byte_dn = 1'b0;
    for (int b = 0; b < NB; b++) cal_taps[b*TW +: TW] = TW'(cal[b]);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R12 reset active", int'(scan_active), 0);
    check("R12 reset byte", int'(cur_byte), 0);
    check("R12 reset strobes", int'(tap_inc | tap_dec | err_clr), 0);
    check("R12 reset left", int'(res_left), 0);
    check("R12 reset right", int'(res_right), 0);
    check("R13 reset tap", int'(cur_tap), cal[0]);

    // First sweep from calibrated taps.
    for (int b = 0; b < NB; b++) push_expect(b, cal[b]);
    run_scan();
    finish_scan();

    // Taps restored (R6), wrap up (R10), current tap view (R13).
    pulse(2);
    check("R10 wrap up", int'(cur_byte), 0);
    for (int k = 0; k < NB; k++) begin
      check($sformatf("R6 restored byte %0d", k), int'(cur_tap), cal[k]);
      pulse(2);
    end
    pulse(3);
    check("R10 wrap down", int'(cur_byte), NB-1);

    // Manual stepping and saturation (R9).
    pulse(3); pulse(3); pulse(3);
    check("R10 step down", int'(cur_byte), 4);
    pulse(0);
    check("R9 ceiling holds", int'(cur_tap), TMAX);
    pulse(1);
    check("R9 manual down", int'(cur_tap), TMAX-1);
    pulse(3);
    pulse(1);
    check("R9 floor holds", int'(cur_tap), 0);
    pulse(0);
    check("R9 manual up", int'(cur_tap), 1);

    // Path selector gate (R3).
    path_sel = 2'd2;
    pulse(0);
    check("R3 gated manual step", int'(cur_tap), 1);
    @(negedge clk) scan_go = 1'b1;
    @(negedge clk) scan_go = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 gated start", int'(scan_active), 0);
    path_sel = 2'd1;

    // Second sweep from the new present taps, with manual inputs poked mid-sweep (R11).
    for (int b = 0; b < NB; b++) home[b] = cal[b];
    home[4] = TMAX-1;
    home[3] = 1;
    for (int b = 0; b < NB; b++) push_expect(b, home[b]);
    pulse(3); pulse(3); pulse(3);
    run_scan();
    repeat (30) @(negedge clk);
    pulse(0); pulse(2); pulse(1); pulse(2);
    finish_scan();
    check("R11 tap of last byte", int'(cur_tap), home[NB-1]);
    @(negedge clk) rd_sel = BW'(3);
    @(negedge clk);
    check("R12 readout select left", int'(res_left), 1);
    check("R12 readout select right", int'(res_right), 9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule